// File: doc/BRIEF.md
# Deferred Condition Flag Resolver

This block lets an integer pipeline postpone condition-flag computation. When an instruction finishes, the pipeline saves only three things: an operation kind, the value it produced and its source operand. The negative, zero, overflow and carry flags are worked out later, and only if something actually needs them. A resolve strobe turns the saved triple into committed flags. The block then rewrites its saved state as already-resolved flags, so a second resolve returns the same answer.

The block also has a multi-precision path. It takes two operands and the current extend bit and forms their sum or difference, adding or subtracting one more when extend is set. It commits the flags, the new extend bit and the result in one cycle. On this path, the zero flag can only stay set or become clear. A chain of extended operations therefore reports zero only when every word in the chain was zero.

Top module: `lcc_top`

## Requirements
- R1: After reset the flags read 0000, the extend bit is 0, the resolved indicator is 1, the error pulse is 0 and the extended result is 0. The saved kind is "flags" with a saved value of 0.
- R2: A save strobe stores the kind, result and source and clears the resolved indicator on the next cycle. The committed flags and extend bit do not change.
- R3: Kind codes: 0 flags, 1 logic, 2 add, 3 subtract, 4 byte compare, 5 word compare, 6 add-extended, 7 subtract-extended, 8 shift. The flags are laid out as N=bit3, Z=bit2, V=bit1, C=bit0. A resolve sets Z when the result is zero and sets N only when the result is nonzero with its top bit set. Logic clears V and C. A resolve of any computed kind commits the flags and sets the resolved indicator one cycle later.
- R4: Add: C means the result is below the source (unsigned). V means signed overflow of (result-source)+source.
- R5: Subtract: the minuend is result+source. C means the minuend is below the source (unsigned). V means signed overflow of minuend-source.
- R6: Byte and word compares apply the subtract rule on the low 8 or 16 bits. N and Z come from those low bits only, and the upper bits have no effect.
- R7: Add-extended: C is result <= source, and V is overflow of (result-source-1)+source+1. Subtract-extended: the minuend is result+source+1, C is minuend <= source, and V is overflow of minuend-source-1.
- R8: Shift: N and Z come from the result, V is 0, and C is 1 exactly when the saved source is nonzero.
- R9: Resolving kind 0 commits bits 3:0 of the saved result as the flags. After any resolve, the saved state becomes kind 0 holding the committed flags, so resolving again gives the same flags.
- R10: Resolving a kind code of 9 or above raises the error output for one cycle. The flags, the extend bit and the resolved indicator stay unchanged.
- R11: An extended operation with a clear extend bit computes A+B or A-B, with the new extend equal to the carry or borrow. With extend set, it computes A+B+1 or A-B-1, with the new extend equal to the carry or borrow of that operation. The result appears on the result output and the flags are resolved as add/subtract or add-extended/subtract-extended, respectively.
- R12: On an extended operation, the committed Z is the new Z ANDed with the previously committed Z.
- R13: When strobes coincide, the extended operation wins over save, and save wins over resolve. Only an extended operation changes the extend bit or the result output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| saveValid | input | 1 | Save strobe |
| saveKind | input | 4 | Kind code to save |
| saveResult | input | DATA_W | Result value to save |
| saveSource | input | DATA_W | Source operand to save |
| resolveStrobe | input | 1 | Resolve the saved state |
| extValid | input | 1 | Extended operation strobe |
| extSub | input | 1 | 1 = subtract, 0 = add |
| extOpA | input | DATA_W | First operand (minuend or addend) |
| extOpB | input | DATA_W | Second operand |
| ccFlags | output | 4 | Committed flags {N,Z,V,C} |
| xBit | output | 1 | Extend bit |
| isResolved | output | 1 | No lazy state pending |
| kindError | output | 1 | Unknown-kind pulse |
| extResult | output | DATA_W | Last extended operation result |

## Verification
The bench drives the signed boundaries 0x7fffffff and 0x80000000, zero results, and all-ones operands, because these expose overflow and borrow rules that were rebuilt wrongly. For example, a swapped operand in the minuend reconstruction flips C on equal operands, and an off-by-one in the extended forms mis-reports carry when the result equals the source. Byte and word compares get operands with noisy upper bits, which catches a design that tests the full word. Extended chains begin from a committed Z of one and of zero, to show Z can only fall. Unknown kinds and coinciding strobes are mixed into the random stream, so a design that commits garbage flags or gets the priority order wrong diverges at once.

// File: rtl/lcc_pkg.sv
package lcc_pkg;

  typedef enum logic [3:0] {
    KIND_FLAGS = 4'd0,
    KIND_LOGIC = 4'd1,
    KIND_ADD   = 4'd2,
    KIND_SUB   = 4'd3,
    KIND_CMPB  = 4'd4,
    KIND_CMPW  = 4'd5,
    KIND_ADDX  = 4'd6,
    KIND_SUBX  = 4'd7,
    KIND_SHIFT = 4'd8
  } lcc_kind_e;

  typedef struct packed {
    logic n;
    logic z;
    logic v;
    logic c;
  } lcc_flags_t;

  typedef struct packed {
    logic doExt;
    logic doSave;
    logic doResolve;
    logic raiseErr;
  } lcc_strobes_t;

endpackage

// File: rtl/lcc_eval.sv
module lcc_eval
  import lcc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic [3:0]   kind,
  input  logic [W-1:0] dest,
  input  logic [W-1:0] src,
  output lcc_flags_t   flags,
  output logic         known
);

  localparam int NUM_CMP = 2;
  localparam logic [W-1:0] ONE = W'(1);

  logic zWide, nWide;
  logic [W-1:0] addTmp, addxTmp, subTmp, subxTmp;
  logic vAdd, vAddx, cSub, vSub, cSubx, vSubx;
  lcc_flags_t cmpFlags [NUM_CMP];

  assign zWide = (dest == '0);
  assign nWide = !zWide && dest[W-1];

  // operand of the addition recovered from the sum
  assign addTmp  = dest - src;
  assign addxTmp = dest - src - ONE;
  assign vAdd    = ((src ^ dest) & ~(addTmp ^ src)) >> (W-1) != '0;
  assign vAddx   = ((src ^ dest) & ~(addxTmp ^ src)) >> (W-1) != '0;

  // minuend recovered from the difference
  assign subTmp  = dest + src;
  assign subxTmp = dest + src + ONE;
  assign cSub    = subTmp < src;
  assign cSubx   = subxTmp <= src;
  assign vSub    = ((subTmp ^ dest) & (subTmp ^ src)) >> (W-1) != '0;
  assign vSubx   = ((subxTmp ^ dest) & (subxTmp ^ src)) >> (W-1) != '0;

  // narrow compares: index 0 byte, index 1 halfword
  for (genvar g = 0; g < NUM_CMP; g++) begin : g_cmp
    localparam int CW = (g == 0) ? 8 : 16;
    logic [CW-1:0] dNar, sNar, mNar;
    assign dNar = dest[CW-1:0];
    assign sNar = src[CW-1:0];
    assign mNar = dNar + sNar;
    assign cmpFlags[g].z = (dNar == '0);
    assign cmpFlags[g].n = (dNar != '0) && dNar[CW-1];
    assign cmpFlags[g].c = mNar < sNar;
    assign cmpFlags[g].v = mNar[CW-1] != dNar[CW-1] && mNar[CW-1] != sNar[CW-1];
  end

  always_comb begin
    flags = '0;
    known = 1'b1;
    case (kind)
      KIND_FLAGS: flags = lcc_flags_t'(dest[3:0]);
      KIND_LOGIC: flags = '{n: nWide, z: zWide, v: 1'b0, c: 1'b0};
      KIND_ADD:   flags = '{n: nWide, z: zWide, v: vAdd, c: dest < src};
      KIND_SUB:   flags = '{n: nWide, z: zWide, v: vSub, c: cSub};
      KIND_CMPB:  flags = cmpFlags[0];
      KIND_CMPW:  flags = cmpFlags[1];
      KIND_ADDX:  flags = '{n: nWide, z: zWide, v: vAddx, c: dest <= src};
      KIND_SUBX:  flags = '{n: nWide, z: zWide, v: vSubx, c: cSubx};
      KIND_SHIFT: flags = '{n: nWide, z: zWide, v: 1'b0, c: src != '0};
      default: begin
        flags = '0;
        known = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/lcc_ctrl.sv
module lcc_ctrl
  import lcc_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         saveValid,
  input  logic         resolveStrobe,
  input  logic         extValid,
  input  logic         kindKnown,
  output lcc_strobes_t strobes,
  output logic         isResolved,
  output logic         kindError
);

  always_comb begin
    strobes = '0;
    if (extValid) begin
      strobes.doExt = 1'b1;
    end else if (saveValid) begin
      strobes.doSave = 1'b1;
    end else if (resolveStrobe) begin
      if (kindKnown) strobes.doResolve = 1'b1;
      else           strobes.raiseErr  = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      isResolved <= 1'b1;
      kindError  <= 1'b0;
    end else begin
      kindError <= strobes.raiseErr;
      if (strobes.doExt || strobes.doResolve) isResolved <= 1'b1;
      else if (strobes.doSave)                isResolved <= 1'b0;
    end
  end

  AST_SAVE_PENDS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doSave |=> !isResolved); // R2
  AST_RESOLVE_MARKS: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doResolve || strobes.doExt) |=> isResolved); // R3
  AST_ERR_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rstN)
    strobes.raiseErr |=> $stable(isResolved)); // R10

endmodule

// File: rtl/lcc_datapath.sv
module lcc_datapath
  import lcc_pkg::*;
#(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rstN,
  input  lcc_strobes_t strobes,
  input  logic [3:0]   saveKind,
  input  logic [W-1:0] saveResult,
  input  logic [W-1:0] saveSource,
  input  logic         extSub,
  input  logic [W-1:0] extOpA,
  input  logic [W-1:0] extOpB,
  output lcc_flags_t   flagsQ,
  output logic         xBit,
  output logic [W-1:0] extResult,
  output logic         kindKnown
);

  localparam logic [W-1:0] ONE = W'(1);

  logic [3:0]   storedKind;
  logic [W-1:0] storedDest, storedSrc;
  lcc_flags_t   resFlags, extFlags, extCommit;
  logic [W-1:0] extRes;
  logic         extXNew, extKnown;
  logic [3:0]   extKind;

  // saved-state evaluator
  lcc_eval #(.W(W)) savedEvalI (
    .kind (storedKind),
    .dest (storedDest),
    .src  (storedSrc),
    .flags(resFlags),
    .known(kindKnown)
  );

  // extended arithmetic with incoming extend bit
  always_comb begin
    if (extSub) begin
      extRes  = xBit ? (extOpA - extOpB - ONE) : (extOpA - extOpB);
      extXNew = xBit ? (extOpA <= extOpB) : (extOpA < extOpB);
      extKind = xBit ? KIND_SUBX : KIND_SUB;
    end else begin
      extRes  = xBit ? (extOpA + extOpB + ONE) : (extOpA + extOpB);
      extXNew = xBit ? (extRes <= extOpB) : (extRes < extOpB);
      extKind = xBit ? KIND_ADDX : KIND_ADD;
    end
  end

  lcc_eval #(.W(W)) extEvalI (
    .kind (extKind),
    .dest (extRes),
    .src  (extOpB),
    .flags(extFlags),
    .known(extKnown)
  );

  always_comb begin
    extCommit   = extFlags;
    extCommit.z = extFlags.z & flagsQ.z;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      storedKind <= KIND_FLAGS;
      storedDest <= '0;
      storedSrc  <= '0;
      flagsQ     <= '0;
      xBit       <= 1'b0;
      extResult  <= '0;
    end else if (strobes.doExt) begin
      storedKind <= KIND_FLAGS;
      storedDest <= W'(extCommit);
      storedSrc  <= extOpB;
      flagsQ     <= extCommit;
      xBit       <= extXNew;
      extResult  <= extRes;
    end else if (strobes.doSave) begin
      storedKind <= saveKind;
      storedDest <= saveResult;
      storedSrc  <= saveSource;
    end else if (strobes.doResolve) begin
      storedKind <= KIND_FLAGS;
      storedDest <= W'(resFlags);
      flagsQ     <= resFlags;
    end
  end

  AST_ERR_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.raiseErr |=> $stable(flagsQ)); // R10
  AST_Z_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doExt && !flagsQ.z) |=> !flagsQ.z); // R12
  AST_X_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.doExt |=> $stable(xBit) && $stable(extResult)); // R13
  AST_NZ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.doResolve && storedKind != KIND_FLAGS) |=> !(flagsQ.n && flagsQ.z)); // R3
  AST_SAVE_KEEPS_FLAGS: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doSave |=> $stable(flagsQ)); // R2
  AST_EXT_KIND_OK: assert property (@(posedge clk) disable iff (!rstN)
    strobes.doExt |-> extKnown); // R11

endmodule

// File: rtl/lcc_top.sv
module lcc_top
  import lcc_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              saveValid,
  input  logic [3:0]        saveKind,
  input  logic [DATA_W-1:0] saveResult,
  input  logic [DATA_W-1:0] saveSource,
  input  logic              resolveStrobe,
  input  logic              extValid,
  input  logic              extSub,
  input  logic [DATA_W-1:0] extOpA,
  input  logic [DATA_W-1:0] extOpB,
  output logic [3:0]        ccFlags,
  output logic              xBit,
  output logic              isResolved,
  output logic              kindError,
  output logic [DATA_W-1:0] extResult
);

  lcc_strobes_t strobes;
  lcc_flags_t   flagsQ;
  logic         kindKnown;

  lcc_ctrl ctrlI (
    .clk          (clk),
    .rstN         (rstN),
    .saveValid    (saveValid),
    .resolveStrobe(resolveStrobe),
    .extValid     (extValid),
    .kindKnown    (kindKnown),
    .strobes      (strobes),
    .isResolved   (isResolved),
    .kindError    (kindError)
  );

  lcc_datapath #(.W(DATA_W)) dpI (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .saveKind  (saveKind),
    .saveResult(saveResult),
    .saveSource(saveSource),
    .extSub    (extSub),
    .extOpA    (extOpA),
    .extOpB    (extOpB),
    .flagsQ    (flagsQ),
    .xBit      (xBit),
    .extResult (extResult),
    .kindKnown (kindKnown)
  );

  assign ccFlags = flagsQ;

endmodule

// File: tb/lcc_top_tb_top.sv
`timescale 1ns/1ps
module lcc_top_tb_top;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic saveValid = 1'b0, resolveStrobe = 1'b0, extValid = 1'b0, extSub = 1'b0;
  logic [3:0] saveKind = '0;
  logic [31:0] saveResult = '0, saveSource = '0, extOpA = '0, extOpB = '0;
  logic [3:0] ccFlags;
  logic xBit, isResolved, kindError;
  logic [31:0] extResult;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  // model state
  bit [3:0]  mKind;
  bit [31:0] mDest, mSrc, mExtRes;
  bit [3:0]  mFlags;
  bit        mX, mRes, mErr;

  always #5 clk = ~clk;

  lcc_top dut_i (
    .clk(clk), .rstN(rstN), .saveValid(saveValid), .saveKind(saveKind),
    .saveResult(saveResult), .saveSource(saveSource), .resolveStrobe(resolveStrobe),
    .extValid(extValid), .extSub(extSub), .extOpA(extOpA), .extOpB(extOpB),
    .ccFlags(ccFlags), .xBit(xBit), .isResolved(isResolved), .kindError(kindError),
    .extResult(extResult)
  );

  function automatic longint sx(longint x, int w);
    if (((x >> (w - 1)) & 1) != 0) return x - (longint'(1) << w);
    return x;
  endfunction

  function automatic bit ovf(longint r, int w);
    return (r > (longint'(1) << (w - 1)) - 1) || (r < -(longint'(1) << (w - 1)));
  endfunction

  // returns {known, N, Z, V, C}
  function automatic bit [4:0] refEval(bit [3:0] k, bit [31:0] d, bit [31:0] s);
    bit n, z, v, c;
    bit [31:0] a;
    longint m, dm, sm, am;
    int w;
    z = (d == 0); n = !z && d[31]; v = 0; c = 0;
    case (k)
      4'd0: return {1'b1, d[3:0]};
      4'd1: ;
      4'd2: begin
        a = d - s;
        c = ((longint'(a) + longint'(s)) >> 32) != 0;
        v = ovf(sx(longint'(a), 32) + sx(longint'(s), 32), 32);
      end
      4'd3: begin
        a = d + s;
        c = a < s;
        v = ovf(sx(longint'(a), 32) - sx(longint'(s), 32), 32);
      end
      4'd4, 4'd5: begin
        w = (k == 4'd4) ? 8 : 16;
        m = (longint'(1) << w) - 1;
        dm = longint'(d) & m; sm = longint'(s) & m;
        am = (longint'(d) + longint'(s)) & m;
        z = (dm == 0); n = !z && (((dm >> (w - 1)) & 1) != 0);
        c = am < sm;
        v = ovf(sx(am, w) - sx(sm, w), w);
      end
      4'd6: begin
        a = d - s - 1;
        c = ((longint'(a) + longint'(s) + 1) >> 32) != 0;
        v = ovf(sx(longint'(a), 32) + sx(longint'(s), 32) + 1, 32);
      end
      4'd7: begin
        a = d + s + 1;
        c = a <= s;
        v = ovf(sx(longint'(a), 32) - sx(longint'(s), 32) - 1, 32);
      end
      4'd8: c = (s != 0);
      default: return 5'b0;
    endcase
    return {1'b1, n, z, v, c};
  endfunction

  task automatic compareAll(string tag);
    checks++;
    if (ccFlags !== mFlags || xBit !== mX || isResolved !== mRes ||
        kindError !== mErr || extResult !== mExtRes) begin
      fails++;
      $display("FAIL %s: flags=%b x=%b res=%b err=%b ext=%h expected flags=%b x=%b res=%b err=%b ext=%h",
               tag, ccFlags, xBit, isResolved, kindError, extResult,
               mFlags, mX, mRes, mErr, mExtRes);
    end
  endtask

  task automatic doOp(bit ex, bit sv, bit rs, bit [3:0] k, bit [31:0] a, bit [31:0] b,
                      bit sub, string tag);
    bit [4:0] r;
    bit [31:0] res;
    bit nx;
    bit [3:0] ek;
    extValid = ex; saveValid = sv; resolveStrobe = rs; saveKind = k;
    saveResult = a; saveSource = b; extOpA = a; extOpB = b; extSub = sub;
    @(posedge clk);
    mErr = 0;
    if (ex) begin
      if (sub) begin
        res = mX ? a - b - 1 : a - b;
        nx  = mX ? (a <= b) : (a < b);
        ek  = mX ? 4'd7 : 4'd3;
      end else begin
        res = mX ? a + b + 1 : a + b;
        nx  = mX ? (res <= b) : (res < b);
        ek  = mX ? 4'd6 : 4'd2;
      end
      r = refEval(ek, res, b);
      r[2] = r[2] & mFlags[2];
      mFlags = r[3:0]; mX = nx; mExtRes = res;
      mKind = 0; mDest = {28'b0, r[3:0]}; mRes = 1;
    end else if (sv) begin
      mKind = k; mDest = a; mSrc = b; mRes = 0;
    end else if (rs) begin
      r = refEval(mKind, mDest, mSrc);
      if (r[4]) begin
        mFlags = r[3:0]; mKind = 0; mDest = {28'b0, r[3:0]}; mRes = 1;
      end else begin
        mErr = 1;
      end
    end
    @(negedge clk);
    extValid = 0; saveValid = 0; resolveStrobe = 0;
    compareAll(tag);
  endtask

  task automatic saveResolve(bit [3:0] k, bit [31:0] d, bit [31:0] s, string tag);
    doOp(0, 1, 0, k, d, s, 0, tag);
    doOp(0, 0, 1, 0, 0, 0, 0, tag);
  endtask

  function automatic bit [31:0] pickVal();
    case ($urandom % 8)
      0: return 32'h0;
      1: return 32'h1;
      2: return 32'h7fffffff;
      3: return 32'h80000000;
      4: return 32'hffffffff;
      5: return {$urandom % 2 == 0 ? 24'h0 : 24'hffffff, 8'($urandom)};
      default: return $urandom;
    endcase
  endfunction

  function automatic string tagFor(bit [3:0] k);
    case (k)
      4'd0: return "R9 flags kind";
      4'd1: return "R3 logic";
      4'd2: return "R4 add";
      4'd3: return "R5 sub";
      4'd4, 4'd5: return "R6 compare";
      4'd6, 4'd7: return "R7 extended kinds";
      4'd8: return "R8 shift";
      default: return "R10 unknown kind";
    endcase
  endfunction

  initial begin
    #1_500_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    mKind = 0; mDest = 0; mSrc = 0; mExtRes = 0; mFlags = 0; mX = 0; mRes = 1; mErr = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    compareAll("R1 reset state");

    // directed corners
    saveResolve(4'd1, 32'h0, 32'h5, "R3 logic zero");
    saveResolve(4'd1, 32'h80000000, 32'h0, "R3 logic negative");
    saveResolve(4'd2, 32'h80000000, 32'h1, "R4 add signed overflow");
    saveResolve(4'd2, 32'h0, 32'h1, "R4 add carry to zero");
    saveResolve(4'd3, 32'h7fffffff, 32'h1, "R5 sub overflow");
    saveResolve(4'd3, 32'hffffffff, 32'h1, "R5 sub borrow");
    saveResolve(4'd4, 32'hffffff00, 32'h01, "R6 byte compare zero low");
    saveResolve(4'd5, 32'h12348000, 32'h0001, "R6 word compare");
    saveResolve(4'd6, 32'h5, 32'h5, "R7 addx equal carries");
    saveResolve(4'd7, 32'hffffffff, 32'h0, "R7 subx borrow");
    saveResolve(4'd8, 32'h10, 32'h0, "R8 shift no carry");
    saveResolve(4'd8, 32'h0, 32'h3, "R8 shift carry zero");
    saveResolve(4'd0, 32'hfffffffa, 32'h0, "R9 flags load");
    doOp(0, 0, 1, 0, 0, 0, 0, "R9 resolve again");
    saveResolve(4'd12, 32'h1, 32'h1, "R10 unknown kind");
    doOp(0, 0, 0, 0, 0, 0, 0, "R10 error pulse ends");
    // sticky Z chain: start from Z=1
    saveResolve(4'd1, 32'h0, 32'h0, "R12 seed zero");
    doOp(1, 0, 0, 0, 32'hffffffff, 32'h1, 0, "R11 add carry out");
    doOp(1, 0, 0, 0, 32'h0, 32'h0, 0, "R11 addx with extend");
    doOp(1, 0, 0, 0, 32'h0, 32'h0, 1, "R12 zero kept cleared");
    doOp(1, 0, 0, 0, 32'h0, 32'h1, 1, "R11 sub borrow");
    doOp(1, 0, 0, 0, 32'h5, 32'h4, 1, "R11 subx with extend");
    doOp(1, 1, 1, 4'd3, 32'h9, 32'h2, 0, "R13 ext over save");
    doOp(0, 1, 1, 4'd8, 32'h0, 32'h1, 0, "R13 save over resolve");
    doOp(0, 0, 1, 0, 0, 0, 0, "R8 shift after priority");

    for (int i = 0; i < 4000; i++) begin
      int sel;
      bit [3:0] k;
      sel = $urandom % 10;
      k = 4'($urandom % 11);
      if (sel < 4)       doOp(0, 1, 0, k, pickVal(), pickVal(), 0, "R2 save");
      else if (sel < 6)  doOp(0, 0, 1, 0, 0, 0, 0, tagFor(mKind));
      else if (sel < 9)  doOp(1, 0, 0, 0, pickVal(), pickVal(), 1'($urandom), "R11 R12 ext");
      else               doOp(1'($urandom), 1'($urandom), 1'($urandom), k,
                              pickVal(), pickVal(), 1'($urandom), "R13 mixed strobes");
    end

    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

endmodule